// File: doc/BRIEF.md
# GPIO Interrupt Bank

This block is a 32-pin general-purpose I/O bank behind a 32-bit register bus. Software sets output values and per-pin output enables, reads the pad inputs through a two-flop synchronizer, and programs pad controls. The pad controls are a pull resistor with a selectable direction and a 3-bit drive-strength code for each pin.

Every pin can raise an interrupt. Three independent per-pin bits select how it senses:
- a sense-type bit picks level or edge;
- a both-edges bit makes either transition count;
- a polarity bit picks rising/high or falling/low.

Raw status is latched per pin, gated by a per-pin enable mask, and cleared by writing ones. A single registered interrupt line reports whether any enabled status bit is pending.

The register window is 0x200 bytes. Each register holds one bit per pin at bit position n. Reads are combinational from the address. A write takes effect at the clock edge where `bus_wr_en` is high. All registers reset to zero on an active-low asynchronous reset.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, and `pin_out`, `pin_oe`, `pad_pull_up`, `pad_pull_dn`, `pad_drive` and `irq` are all 0.
- R2: The output-value register (0x04) drives `pin_out` and the output-enable register (0x08) drives `pin_oe`. Both read back what was written, and neither changes without a write.
- R3: Offset 0x00 returns `pin_in` after a two-flop synchronizer. A change applied before clock edge k becomes readable after edge k+1. Writes to 0x00 are ignored.
- R4: With sense-type (0x0C) bit 0 and both-edges (0x10) bit 0, the polarity bit (0x14) selects the edge that latches raw status (0x1C): 1 selects a rising edge and 0 a falling edge. The opposite edge latches nothing.
- R5: With both-edges bit 1 in edge mode, rising and falling transitions both latch status, whatever the polarity bit holds.
- R6: Edge-latched status stays set until a 1 is written to that bit of the clear register (0x24). Writing 0 there changes nothing.
- R7: With sense-type bit 1, raw status follows the synchronized level: polarity 1 makes high active and polarity 0 makes low active. A clear write while the level is active leaves the bit set, and the bit drops once the level goes inactive.
- R8: The enable mask (0x18) has 1 meaning enabled, and the masked status (0x20) reads raw status AND mask.
- R9: `irq` is a register holding the OR of all masked status bits, so it follows the masked status one clock later.
- R10: When an edge would latch a pin's status in the same cycle that a clear write hits that bit, the status ends up set.
- R11: Pull enable (0x38) and pull select (0x34) give `pad_pull_up` = enable AND select and `pad_pull_dn` = enable AND NOT select. With enable 0, no pull is active.
- R12: Three drive planes at 0x58, 0x5C and 0x60 hold bit 0, bit 1 and bit 2 of each pin's drive code. The code for pin n appears on `pad_drive[3n+2:3n]`, and a code c stands for 2*(c+1) mA.
- R13: Unmapped or unaligned offsets read 0 and ignore writes. The raw status and masked status registers cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 9 | Byte offset inside the bank window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Pad input levels, asynchronous |
| pin_out | output | NUM_PINS | Output values to the pads |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pad_pull_up | output | NUM_PINS | Pull-up active per pin |
| pad_pull_dn | output | NUM_PINS | Pull-down active per pin |
| pad_drive | output | 3*NUM_PINS | Drive-strength code, three bits per pin |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the bank with its default of 32 pins. With that width, both pin 0 and the top pin 31 can be reached through every register, including the zero-extension edge of the read path. Both ends are given different sense modes at once, so a polarity or lane swap shows up. The two-flop input delay, the one-cycle `irq` register delay and the set-versus-clear collision are all checked at exact cycle positions, which only works because the sensing path has a fixed depth at this width.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WINDOW_BYTES = 512;
    localparam int ADDR_W       = $clog2(WINDOW_BYTES);
    localparam int DATA_W       = 32;
    localparam int DRV_BITS     = 3;
    localparam int DRV_STEP     = 4;

    typedef logic [ADDR_W-1:0] addr_t;

    // Byte offsets inside one bank window
    localparam addr_t OFF_PIN_IN   = 9'h000;
    localparam addr_t OFF_DOUT     = 9'h004;
    localparam addr_t OFF_OE       = 9'h008;
    localparam addr_t OFF_SENSE    = 9'h00C;
    localparam addr_t OFF_BOTH     = 9'h010;
    localparam addr_t OFF_POL      = 9'h014;
    localparam addr_t OFF_MASK     = 9'h018;
    localparam addr_t OFF_RAW      = 9'h01C;
    localparam addr_t OFF_MSTAT    = 9'h020;
    localparam addr_t OFF_CLR      = 9'h024;
    localparam addr_t OFF_PSEL     = 9'h034;
    localparam addr_t OFF_PEN      = 9'h038;
    localparam addr_t OFF_DRV_BASE = 9'h058;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_cur,
    output logic [WIDTH-1:0] sync_prev
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] cur;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_cur  = st_q.cur;
    assign sync_prev = st_q.prev;

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_now,
    input  logic [WIDTH-1:0] lvl_old,
    input  logic [WIDTH-1:0] sense_level,
    input  logic [WIDTH-1:0] both_edges,
    input  logic [WIDTH-1:0] polarity,
    input  logic [WIDTH-1:0] clear_bits,
    output logic [WIDTH-1:0] raw_status
);

    logic [WIDTH-1:0] hit;

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic rise, fall, edge_hit, level_hit;
        assign rise      = lvl_now[p] & ~lvl_old[p];
        assign fall      = ~lvl_now[p] & lvl_old[p];
        assign edge_hit  = both_edges[p] ? (rise | fall)
                                         : (polarity[p] ? rise : fall);
        assign level_hit = polarity[p] ? lvl_now[p] : ~lvl_now[p];
        assign hit[p]    = sense_level[p] ? level_hit : edge_hit;
    end

    typedef struct packed {
        logic [WIDTH-1:0] raw;
    } sense_t;

    sense_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Level pins track the active level; edge pins hold until cleared.
        // A new hit overrides a clear in the same cycle.
        st_d.raw = hit | (st_q.raw & ~clear_bits & ~sense_level);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_status = st_q.raw;

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  addr_t                          wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [WIDTH-1:0]               dout,
    output logic [WIDTH-1:0]               oe,
    output logic [WIDTH-1:0]               sense_level,
    output logic [WIDTH-1:0]               both_edges,
    output logic [WIDTH-1:0]               polarity,
    output logic [WIDTH-1:0]               mask,
    output logic [WIDTH-1:0]               pull_sel,
    output logic [WIDTH-1:0]               pull_en,
    output logic [DRV_BITS-1:0][WIDTH-1:0] drv_plane
);

    typedef struct packed {
        logic [WIDTH-1:0]               dout;
        logic [WIDTH-1:0]               oe;
        logic [WIDTH-1:0]               lvl;
        logic [WIDTH-1:0]               both;
        logic [WIDTH-1:0]               pol;
        logic [WIDTH-1:0]               mask;
        logic [WIDTH-1:0]               psel;
        logic [WIDTH-1:0]               pen;
        logic [DRV_BITS-1:0][WIDTH-1:0] drv;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [WIDTH-1:0] wbits;

    assign wbits = wr_data[WIDTH-1:0];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                OFF_DOUT:  cfg_d.dout = wbits;
                OFF_OE:    cfg_d.oe   = wbits;
                OFF_SENSE: cfg_d.lvl  = wbits;
                OFF_BOTH:  cfg_d.both = wbits;
                OFF_POL:   cfg_d.pol  = wbits;
                OFF_MASK:  cfg_d.mask = wbits;
                OFF_PSEL:  cfg_d.psel = wbits;
                OFF_PEN:   cfg_d.pen  = wbits;
                default:   ;
            endcase
            for (int i = 0; i < DRV_BITS; i++) begin
                if (wr_addr == OFF_DRV_BASE + addr_t'(DRV_STEP * i)) begin
                    cfg_d.drv[i] = wbits;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dout        = cfg_q.dout;
    assign oe          = cfg_q.oe;
    assign sense_level = cfg_q.lvl;
    assign both_edges  = cfg_q.both;
    assign polarity    = cfg_q.pol;
    assign mask        = cfg_q.mask;
    assign pull_sel    = cfg_q.psel;
    assign pull_en     = cfg_q.pen;
    assign drv_plane   = cfg_q.drv;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr_en,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]          pin_in,
    output logic [NUM_PINS-1:0]          pin_out,
    output logic [NUM_PINS-1:0]          pin_oe,
    output logic [NUM_PINS-1:0]          pad_pull_up,
    output logic [NUM_PINS-1:0]          pad_pull_dn,
    output logic [DRV_BITS*NUM_PINS-1:0] pad_drive,
    output logic                         irq
);

    logic [NUM_PINS-1:0]               sync_cur, sync_prev;
    logic [NUM_PINS-1:0]               cfg_dout, cfg_oe, cfg_lvl, cfg_both, cfg_pol;
    logic [NUM_PINS-1:0]               cfg_mask, cfg_psel, cfg_pen;
    logic [DRV_BITS-1:0][NUM_PINS-1:0] cfg_drv;
    logic [NUM_PINS-1:0]               clr_bits, raw_st, masked_st;

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (pin_in),
        .sync_cur  (sync_cur),
        .sync_prev (sync_prev)
    );

    gpio_cfg_regs #(.WIDTH(NUM_PINS)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr_en),
        .wr_addr     (bus_addr),
        .wr_data     (bus_wdata),
        .dout        (cfg_dout),
        .oe          (cfg_oe),
        .sense_level (cfg_lvl),
        .both_edges  (cfg_both),
        .polarity    (cfg_pol),
        .mask        (cfg_mask),
        .pull_sel    (cfg_psel),
        .pull_en     (cfg_pen),
        .drv_plane   (cfg_drv)
    );

    assign clr_bits = (bus_wr_en && bus_addr == OFF_CLR) ? bus_wdata[NUM_PINS-1:0] : '0;

    gpio_irq_sense #(.WIDTH(NUM_PINS)) u_sense (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_now     (sync_cur),
        .lvl_old     (sync_prev),
        .sense_level (cfg_lvl),
        .both_edges  (cfg_both),
        .polarity    (cfg_pol),
        .clear_bits  (clr_bits),
        .raw_status  (raw_st)
    );

    assign masked_st = raw_st & cfg_mask;

    // Combined interrupt register
    typedef struct packed {
        logic irq;
    } top_t;

    top_t top_d, top_q;

    always_comb begin
        top_d     = top_q;
        top_d.irq = |masked_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign irq = top_q.irq;

    // Read path
    always_comb begin
        case (bus_addr)
            OFF_PIN_IN: bus_rdata = DATA_W'(sync_cur);
            OFF_DOUT:   bus_rdata = DATA_W'(cfg_dout);
            OFF_OE:     bus_rdata = DATA_W'(cfg_oe);
            OFF_SENSE:  bus_rdata = DATA_W'(cfg_lvl);
            OFF_BOTH:   bus_rdata = DATA_W'(cfg_both);
            OFF_POL:    bus_rdata = DATA_W'(cfg_pol);
            OFF_MASK:   bus_rdata = DATA_W'(cfg_mask);
            OFF_RAW:    bus_rdata = DATA_W'(raw_st);
            OFF_MSTAT:  bus_rdata = DATA_W'(masked_st);
            OFF_PSEL:   bus_rdata = DATA_W'(cfg_psel);
            OFF_PEN:    bus_rdata = DATA_W'(cfg_pen);
            default:    bus_rdata = '0;
        endcase
        for (int i = 0; i < DRV_BITS; i++) begin
            if (bus_addr == OFF_DRV_BASE + addr_t'(DRV_STEP * i)) begin
                bus_rdata = DATA_W'(cfg_drv[i]);
            end
        end
    end

    // Pad controls
    assign pin_out     = cfg_dout;
    assign pin_oe      = cfg_oe;
    assign pad_pull_up = cfg_pen & cfg_psel;
    assign pad_pull_dn = cfg_pen & ~cfg_psel;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_drv
        for (genvar b = 0; b < DRV_BITS; b++) begin : g_bit
            assign pad_drive[p*DRV_BITS + b] = cfg_drv[b][p];
        end
    end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr_en,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq,
    input logic [NUM_PINS-1:0] raw_st,
    input logic [NUM_PINS-1:0] mask_st,
    input logic [NUM_PINS-1:0] lvl_st
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (!irq && pin_oe == '0 && pin_out == '0)); // R1

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_en |=> ($stable(pin_out) && $stable(pin_oe))); // R2

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_en |=> (($past(raw_st) & ~$past(lvl_st) & ~raw_st) == '0)); // R6

    AST_MSTAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_MSTAT) |-> (bus_rdata == DATA_W'(raw_st & mask_st))); // R8

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raw_st & mask_st)) |=> irq); // R9

    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(raw_st & mask_st)) |=> !irq); // R9

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .raw_st    (raw_st),
    .mask_st   (cfg_mask),
    .lvl_st    (cfg_lvl)
);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
    import gpio_bank_pkg::*;

    localparam int NP = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pin_in = '0;
    logic [NP-1:0]     pin_out, pin_oe, pad_pull_up, pad_pull_dn;
    logic [3*NP-1:0]   pad_drive;
    logic              irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    gpio_irq_bank #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pad_pull_up(pad_pull_up),
        .pad_pull_dn(pad_pull_dn), .pad_drive(pad_drive), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    // Call just after a falling edge
    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(OFF_DOUT, v);  check("R1 dout", v, 0);
        rd(OFF_MASK, v);  check("R1 mask", v, 0);
        rd(OFF_RAW, v);   check("R1 raw", v, 0);
        check("R1 pins", {pin_out | pin_oe | pad_pull_up | pad_pull_dn}, 0);
        check("R1 drive/irq", {31'(|pad_drive), irq}, 0);
    endtask

    task automatic t_out_regs();
        logic [31:0] v;
        wr(OFF_DOUT, 32'hA5A5_0F0F);
        wr(OFF_OE,   32'hFFFF_0000);
        check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        check("R2 pin_oe",  pin_oe,  32'hFFFF_0000);
        rd(OFF_OE, v); check("R2 oe readback", v, 32'hFFFF_0000);
    endtask

    task automatic t_din();
        logic [31:0] v;
        wr(OFF_PIN_IN, 32'hFFFF_FFFF);
        pin_in = 32'h8000_0001;
        rd(OFF_PIN_IN, v); check("R3 before edge", v, 0);
        @(negedge clk);
        rd(OFF_PIN_IN, v); check("R3 after one edge", v, 0);
        @(negedge clk);
        rd(OFF_PIN_IN, v); check("R3 after two edges", v, 32'h8000_0001);
        pin_in = '0;
        settle();
    endtask

    task automatic t_edge_pol();
        logic [31:0] v;
        wr(OFF_POL, 32'h0000_0001);
        wr(OFF_CLR, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(OFF_RAW, v); check("R4 idle", v, 0);
        pin_in = 32'h0000_0001; settle();
        rd(OFF_RAW, v); check("R4 rising pol1", v, 32'h0000_0001);
        pin_in = 32'h8000_0001; settle();
        rd(OFF_RAW, v); check("R4 rising pol0 ignored", v, 32'h0000_0001);
        pin_in = 32'h0000_0000; settle();
        rd(OFF_RAW, v); check("R4 falling", v, 32'h8000_0001);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        wr(OFF_CLR, 32'h0);
        rd(OFF_RAW, v); check("R6 zero write", v, 32'h8000_0001);
        wr(OFF_CLR, 32'h1);
        rd(OFF_RAW, v); check("R6 clear one", v, 32'h8000_0000);
        wr(OFF_CLR, 32'h8000_0000);
        rd(OFF_RAW, v); check("R6 clear top", v, 0);
    endtask

    task automatic t_dual();
        logic [31:0] v;
        wr(OFF_BOTH, 32'h10);
        pin_in = 32'h10; settle();
        rd(OFF_RAW, v); check("R5 rise", v, 32'h10);
        wr(OFF_CLR, 32'h10);
        pin_in = 32'h0; settle();
        rd(OFF_RAW, v); check("R5 fall", v, 32'h10);
        wr(OFF_BOTH, 32'h0);
        wr(OFF_CLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(OFF_POL, 32'h0000_0101);
        wr(OFF_SENSE, 32'h0000_0300);
        wr(OFF_CLR, 32'hFFFF_FFFF);
        rd(OFF_RAW, v); check("R7 low active survives clear", v, 32'h200);
        pin_in = 32'h300; settle();
        rd(OFF_RAW, v); check("R7 high active", v, 32'h100);
        pin_in = 32'h0; settle();
        rd(OFF_RAW, v); check("R7 follows level", v, 32'h200);
        wr(OFF_SENSE, 32'h0);
        wr(OFF_CLR, 32'hFFFF_FFFF);
        rd(OFF_RAW, v); check("R7 restore", v, 0);
    endtask

    task automatic t_mask_irq();
        logic [31:0] v;
        pin_in = 32'h1; settle();
        rd(OFF_MSTAT, v); check("R8 masked off", v, 0);
        check("R9 irq masked", {31'b0, irq}, 0);
        wr(OFF_MASK, 32'h1);
        check("R9 irq registered", {31'b0, irq}, 0);
        rd(OFF_MSTAT, v); check("R8 masked on", v, 32'h1);
        @(negedge clk);
        check("R9 irq asserted", {31'b0, irq}, 1);
        wr(OFF_MASK, 32'hFFFF_FFFE);
        @(negedge clk);
        check("R9 irq dropped", {31'b0, irq}, 0);
        rd(OFF_MSTAT, v); check("R8 other bits", v, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        pin_in = 32'h0; settle();
        @(negedge clk); pin_in = 32'h1;
        @(negedge clk);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = OFF_CLR; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        rd(OFF_RAW, v); check("R10 set beats clear", v, 32'h1);
        wr(OFF_CLR, 32'h1);
        rd(OFF_RAW, v); check("R10 later clear", v, 0);
    endtask

    task automatic t_pull();
        wr(OFF_PEN,  32'h3);
        wr(OFF_PSEL, 32'h5);
        check("R11 pull up", pad_pull_up, 32'h1);
        check("R11 pull down", pad_pull_dn, 32'h2);
    endtask

    task automatic t_drive();
        logic [2:0]  code [NP];
        logic [31:0] plane [3];
        logic [31:0] v;
        for (int p = 0; p < NP; p++) code[p] = 3'd0;
        code[0]  = 3'(16 / 2 - 1);
        code[5]  = 3'(6 / 2 - 1);
        code[31] = 3'(12 / 2 - 1);
        for (int b = 0; b < 3; b++) begin
            plane[b] = '0;
            for (int p = 0; p < NP; p++) plane[b][p] = code[p][b];
            wr(OFF_DRV_BASE + ADDR_W'(4 * b), plane[b]);
        end
        check("R12 pin0 16mA", 32'(pad_drive[0 +: 3]), 7);
        check("R12 pin5 6mA", 32'(pad_drive[15 +: 3]), 2);
        check("R12 pin31 12mA", 32'(pad_drive[93 +: 3]), 5);
        check("R12 pin1 2mA", 32'(pad_drive[3 +: 3]), 0);
        @(negedge clk);
        rd(OFF_DRV_BASE + 9'h4, v); check("R12 plane1 readback", v, 32'h0000_0021);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(9'h028, 32'hFFFF_FFFF);
        rd(9'h028, v); check("R13 hole reads 0", v, 0);
        wr(OFF_RAW, 32'hFFFF_FFFF);
        wr(OFF_MSTAT, 32'hFFFF_FFFF);
        rd(OFF_RAW, v); check("R13 raw not writable", v, 0);
        wr(9'h005, 32'hFFFF_FFFF);
        rd(OFF_DOUT, v); check("R13 unaligned ignored", v, 32'hA5A5_0F0F);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_out_regs();
        t_din();
        t_edge_pol();
        t_sticky();
        t_dual();
        t_level();
        t_mask_irq();
        t_set_wins();
        t_pull();
        t_drive();
        t_unmapped();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule